// File: doc/BRIEF.md
# Grouped Level Interrupt Steering Aggregator

The block gathers a parameterised number of level-sensitive interrupt inputs. The count is a multiple of 32. Each input passes through a two-flop synchroniser and can also be forced pending by software. A per-input enable mask then gates it. The enabled pending inputs are ORed in fixed groups of 64 onto a small set of level-sensitive output lines, one line per group, rounded up, with at most eight lines. A master disable bit can hold any single line low. A one-hot channel control word decides whether the block drives its outputs at all. Outputs are live only while the bit matching the block's own channel number is set.

Software reaches the block through a word-addressed read/write port, where one address step is one 32-bit word. Mask, force and status each form a bank of N = inputs/32 words. The three banks sit back to back after the channel word: mask, then force, then status. They are followed by the master disable word and the master status word. Inside every bank the word order is reversed, so the highest-numbered inputs live in the lowest word of the bank. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_steer_agg`

## Requirements
- R1: After a synchronous active-high reset, all mask, force, channel and master disable state is zero, every output line is low, and every register reads back as zero.
- R2: The word address map is: channel word at 0; mask words at 1..N; force words at N+1..2N; status words at 2N+1..3N; master disable at 3N+1; master status at 3N+2. Byte offsets are four times these. Channel, mask, force and master disable read back what was written. Addresses beyond 3N+2 read zero and ignore writes.
- R3: Inputs 32k..32k+31 map to word N-1-k of each bank. Input 32k+b occupies bit b of that word.
- R4: Status bit for input i equals (synchronised raw input i OR force bit i) AND mask bit i. A mask bit of 1 enables the input. Writes to status addresses change no state.
- R5: Output line g is high exactly when some status bit for inputs 64g..64g+63 is set, the channel gate is open and master disable bit g is clear.
- R6: Setting master disable bit g forces output g low from the cycle after the write, while other lines keep working.
- R7: Output lines are all low unless bit CHAN_ID of the channel word is set.
- R8: Master status bit g reads back the current level of output g.
- R9: A raw input change reaches the outputs three clock edges later (two synchroniser stages plus the output register). A force or mask write reaches the outputs one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | NUM_IN | Asynchronous level-sensitive interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq_out | output | NUM_GRP | Level-sensitive grouped output lines |

## Verification
A raw input is due at the outputs on the third rising edge after it changes. A mask, force, master disable or channel write takes effect on the edge after the write edge. Read data is due on the edge that samples the read strobe. The bench drives every stimulus just after a falling edge and samples on a later falling edge, counted against those latencies. On the raw path it also samples one edge early and checks that the output has not yet moved. A sweep over every input confirms both the group output and the reversed word position of the status bit.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int ADDR_W   = 8;
    localparam int WORD_W   = 32;
    localparam int GRP_SIZE = 64;
    localparam int MAX_GRP  = 8;
    localparam int IDX_W    = 5;

    typedef enum logic [2:0] {
        RG_CHAN,
        RG_MASK,
        RG_FORCE,
        RG_STATUS,
        RG_MDIS,
        RG_MSTAT,
        RG_NONE
    } reg_region_e;

    typedef struct packed {
        reg_region_e       region;
        logic [IDX_W-1:0]  idx;
    } reg_sel_t;

    function automatic int words_of(input int n_in);
        return n_in / WORD_W;
    endfunction

    function automatic int groups_of(input int n_in);
        return (n_in + GRP_SIZE - 1) / GRP_SIZE;
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input int nw);
        reg_sel_t s;
        int ai;
        ai = int'(a);
        s.idx = '0;
        if (ai == 0) begin
            s.region = RG_CHAN;
        end else if (ai <= nw) begin
            s.region = RG_MASK;
            s.idx    = IDX_W'(ai - 1);
        end else if (ai <= 2 * nw) begin
            s.region = RG_FORCE;
            s.idx    = IDX_W'(ai - 1 - nw);
        end else if (ai <= 3 * nw) begin
            s.region = RG_STATUS;
            s.idx    = IDX_W'(ai - 1 - 2 * nw);
        end else if (ai == 3 * nw + 1) begin
            s.region = RG_MDIS;
        end else if (ai == 3 * nw + 2) begin
            s.region = RG_MSTAT;
        end else begin
            s.region = RG_NONE;
        end
        return s;
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int NUM_IN = 128,
    localparam int NWORDS = words_of(NUM_IN),
    localparam int NGRP   = groups_of(NUM_IN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    input  logic [NUM_IN-1:0]  status_flat,
    input  logic [NGRP-1:0]    out_level,
    output logic [NUM_IN-1:0]  mask_flat,
    output logic [NUM_IN-1:0]  force_flat,
    output logic [WORD_W-1:0]  chan_word,
    output logic [NGRP-1:0]    mdis_bits
);

    reg_sel_t           sel;
    logic [WORD_W-1:0]  rd_val;

    assign sel = decode_addr(addr, NWORDS);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_flat  <= '0;
            force_flat <= '0;
            chan_word  <= '0;
            mdis_bits  <= '0;
            rdata      <= '0;
        end else begin
            if (wr_en) begin
                case (sel.region)
                    RG_CHAN: chan_word <= wdata;
                    RG_MASK: begin
                        for (int w = 0; w < NWORDS; w++) begin
                            if (sel.idx == IDX_W'(w))
                                mask_flat[WORD_W*(NWORDS-1-w) +: WORD_W] <= wdata;
                        end
                    end
                    RG_FORCE: begin
                        for (int w = 0; w < NWORDS; w++) begin
                            if (sel.idx == IDX_W'(w))
                                force_flat[WORD_W*(NWORDS-1-w) +: WORD_W] <= wdata;
                        end
                    end
                    RG_MDIS: mdis_bits <= wdata[NGRP-1:0];
                    default: ;
                endcase
            end
            if (rd_en)
                rdata <= rd_val;
        end
    end

    always_comb begin
        rd_val = '0;
        case (sel.region)
            RG_CHAN: rd_val = chan_word;
            RG_MASK: begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (sel.idx == IDX_W'(w))
                        rd_val = mask_flat[WORD_W*(NWORDS-1-w) +: WORD_W];
                end
            end
            RG_FORCE: begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (sel.idx == IDX_W'(w))
                        rd_val = force_flat[WORD_W*(NWORDS-1-w) +: WORD_W];
                end
            end
            RG_STATUS: begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (sel.idx == IDX_W'(w))
                        rd_val = status_flat[WORD_W*(NWORDS-1-w) +: WORD_W];
                end
            end
            RG_MDIS:  rd_val[NGRP-1:0] = mdis_bits;
            RG_MSTAT: rd_val[NGRP-1:0] = out_level;
            default:  rd_val = '0;
        endcase
    end

    // R4
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.region == RG_STATUS) |=> ($stable(mask_flat) && $stable(force_flat)));

    // R8
    mstat_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel.region == RG_MSTAT) |=> (rdata[NGRP-1:0] == $past(out_level)));

endmodule

// File: rtl/irqagg_combine.sv
module irqagg_combine
    import irqagg_pkg::*;
#(
    parameter int NUM_IN = 128,
    localparam int NGRP = groups_of(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] status_flat,
    input  logic              gate_open,
    input  logic [NGRP-1:0]   mdis_bits,
    output logic [NGRP-1:0]   irq_q
);

    logic [NGRP-1:0] grp_or;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GRP_SIZE;
        localparam int HI = ((LO + GRP_SIZE) < NUM_IN) ? (LO + GRP_SIZE) : NUM_IN;
        assign grp_or[g] = |status_flat[HI-1:LO];

        // R5
        grp_source_chk: assert property (@(posedge clk) disable iff (rst)
            irq_q[g] |-> $past(grp_or[g]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= '0;
        else
            irq_q <= grp_or & ~mdis_bits & {NGRP{gate_open}};
    end

endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
    import irqagg_pkg::*;
#(
    parameter int NUM_IN  = 128,
    parameter int CHAN_ID = 0,
    localparam int NGRP   = groups_of(NUM_IN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IN-1:0]  irq_raw,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NGRP-1:0]    irq_out
);

    if ((NUM_IN % WORD_W) != 0 || NGRP > MAX_GRP || NUM_IN == 0) begin : g_bad_cfg
        $error("irq_steer_agg: unsupported input count");
    end

    logic [NUM_IN-1:0]  sync_in;
    logic [NUM_IN-1:0]  mask_flat;
    logic [NUM_IN-1:0]  force_flat;
    logic [NUM_IN-1:0]  status_flat;
    logic [WORD_W-1:0]  chan_word;
    logic [NGRP-1:0]    mdis_bits;
    logic               gate_open;

    irqagg_sync #(.WIDTH(NUM_IN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_raw),
        .sync_out (sync_in)
    );

    assign status_flat = (sync_in | force_flat) & mask_flat;
    assign gate_open   = chan_word[CHAN_ID];

    irqagg_regs #(.NUM_IN(NUM_IN)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr),
        .rd_en       (reg_rd),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .status_flat (status_flat),
        .out_level   (irq_out),
        .mask_flat   (mask_flat),
        .force_flat  (force_flat),
        .chan_word   (chan_word),
        .mdis_bits   (mdis_bits)
    );

    irqagg_combine #(.NUM_IN(NUM_IN)) u_comb (
        .clk         (clk),
        .rst         (rst),
        .status_flat (status_flat),
        .gate_open   (gate_open),
        .mdis_bits   (mdis_bits),
        .irq_q       (irq_out)
    );

    // R6
    mdis_block_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_out & $past(mdis_bits)) == '0));

    // R7
    chan_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_word[CHAN_ID] |=> (irq_out == '0));

endmodule

// File: tb/irq_steer_agg_tb.sv
module irq_steer_agg_tb;

    localparam int NI   = 128;
    localparam int NW   = NI / 32;
    localparam int NG   = 2;
    localparam int CHID = 2;

    localparam int A_CHAN  = 0;
    localparam int A_MASK  = 1;
    localparam int A_FORCE = 1 + NW;
    localparam int A_STAT  = 1 + 2 * NW;
    localparam int A_MDIS  = 1 + 3 * NW;
    localparam int A_MSTAT = 2 + 3 * NW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NI-1:0]  irq_raw = '0;
    logic           reg_wr = 1'b0;
    logic           reg_rd = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NG-1:0]  irq_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_steer_agg #(.NUM_IN(NI), .CHAN_ID(CHID)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_raw   (irq_raw),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 8'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every mapped register and outputs
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        for (int a = 0; a <= A_MSTAT; a++) begin
            rd(a, v);
            chk("R1 reg", v, 32'h0);
        end

        // R2: readback of writable words, unmapped address
        for (int w = 0; w < NW; w++) begin
            wr(A_MASK + w, 32'hA5000000 | 32'(w));
            wr(A_FORCE + w, 32'h5A000000 | 32'(w));
        end
        for (int w = 0; w < NW; w++) begin
            rd(A_MASK + w, v);  chk("R2 mask", v, 32'hA5000000 | 32'(w));
            rd(A_FORCE + w, v); chk("R2 force", v, 32'h5A000000 | 32'(w));
        end
        wr(A_CHAN, 32'h0000_0040); rd(A_CHAN, v); chk("R2 chan", v, 32'h40);
        wr(A_MDIS, 32'h3);         rd(A_MDIS, v); chk("R2 mdis", v, 32'h3);
        wr(A_MSTAT + 1, 32'hFFFF_FFFF); rd(A_MSTAT + 1, v); chk("R2 unmapped", v, 32'h0);

        // clean setup: all enabled, no force, gate open
        for (int w = 0; w < NW; w++) begin
            wr(A_MASK + w, 32'hFFFF_FFFF);
            wr(A_FORCE + w, 32'h0);
        end
        wr(A_MDIS, 32'h0);
        wr(A_CHAN, 32'(1) << CHID);
        wait_n(2);

        // R3 R5 R9: sweep every raw input
        for (int i = 0; i < NI; i++) begin
            irq_raw = '0;
            irq_raw[i] = 1'b1;
            wait_n(2);
            if (i == 0 || i == 127) chk("R9 raw early", 32'(irq_out), 32'h0);
            wait_n(1);
            chk("R5 group out", 32'(irq_out), 32'(1) << (i / 64));
            rd(A_STAT + (NW - 1 - i / 32), v);
            chk("R3 status word", v, 32'(1) << (i % 32));
            rd(A_STAT + (i / 32), v);
            if ((NW - 1 - i / 32) != (i / 32))
                chk("R3 other word", v, 32'h0);
            irq_raw = '0;
            wait_n(3);
            chk("R5 out drops", 32'(irq_out), 32'h0);
        end

        // R4: mask blocks, force pends, status write ignored
        irq_raw = '0;
        irq_raw[70] = 1'b1;
        wr(A_MASK + (NW - 1 - 2), 32'h0);
        wait_n(3);
        chk("R4 masked out", 32'(irq_out), 32'h0);
        rd(A_STAT + (NW - 1 - 2), v); chk("R4 masked status", v, 32'h0);
        wr(A_MASK + (NW - 1 - 2), 32'h0000_0040);
        chk("R9 mask early", 32'(irq_out), 32'h0);
        wait_n(1);
        chk("R4 unmasked out", 32'(irq_out), 32'h2);
        irq_raw = '0;
        wait_n(3);
        chk("R4 raw removed", 32'(irq_out), 32'h0);

        wr(A_FORCE + (NW - 1 - 0), 32'h0000_0008);
        chk("R9 force early", 32'(irq_out), 32'h0);
        wait_n(1);
        chk("R4 force out", 32'(irq_out), 32'h1);
        rd(A_STAT + (NW - 1), v); chk("R4 force status", v, 32'h8);
        wr(A_FORCE + (NW - 1), 32'h0);
        wait_n(1);
        chk("R4 force cleared", 32'(irq_out), 32'h0);

        wr(A_STAT + 1, 32'hFFFF_FFFF);
        wait_n(2);
        chk("R4 status write out", 32'(irq_out), 32'h0);
        rd(A_STAT + 1, v);  chk("R4 status write status", v, 32'h0);
        rd(A_FORCE + 1, v); chk("R4 status write force", v, 32'h0);

        // R6 R8: master disable and master status
        irq_raw = '0;
        irq_raw[5]  = 1'b1;
        irq_raw[100] = 1'b1;
        wait_n(3);
        chk("R5 both groups", 32'(irq_out), 32'h3);
        rd(A_MSTAT, v); chk("R8 mstat both", v, 32'h3);
        wr(A_MDIS, 32'h2);
        wait_n(1);
        chk("R6 group1 disabled", 32'(irq_out), 32'h1);
        rd(A_MSTAT, v); chk("R8 mstat one", v, 32'h1);
        wr(A_MDIS, 32'h1);
        wait_n(1);
        chk("R6 group0 disabled", 32'(irq_out), 32'h2);
        wr(A_MDIS, 32'h0);
        wait_n(1);
        chk("R6 reenabled", 32'(irq_out), 32'h3);

        // R7: channel gate
        wr(A_CHAN, 32'(1) << (CHID + 1));
        wait_n(1);
        chk("R7 wrong channel", 32'(irq_out), 32'h0);
        rd(A_MSTAT, v); chk("R8 mstat gated", v, 32'h0);
        wr(A_CHAN, 32'h0);
        wait_n(1);
        chk("R7 no channel", 32'(irq_out), 32'h0);
        wr(A_CHAN, 32'(1) << CHID);
        wait_n(1);
        chk("R7 right channel", 32'(irq_out), 32'h3);

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 out after reset", 32'(irq_out), 32'h0);
        rd(A_MASK, v); chk("R1 mask after reset", v, 32'h0);
        rd(A_CHAN, v); chk("R1 chan after reset", v, 32'h0);

        finish_run();
    end

endmodule